// File: doc/BRIEF.md
# Fast Command Decoder with Embedded Slow Control

This block sits behind a symbol decoder that recovers one 4-bit command value per 40 MHz word clock from the downlink. Each word, the decoder presents the value together with a valid flag and a flag that marks the symbol as uncorrectable. The block turns each accepted value into a single-cycle control pulse on a dedicated output. Seven codes drive chip-wide actions: a trigger, a register reset, a calibration-pulse start, a resync, resets of the event and bunch counters, and a run-mode toggle.

Two more codes each carry one slow-control bit. A configuration stream therefore rides inside the fast command stream at one bit per word clock, 40 Mb/s, and needs no separate serial management bus. A slow-control strobe marks each such bit for the register file downstream. The remaining seven code values are unassigned. An unassigned value, or any symbol flagged as uncorrectable, yields only an error pulse, so a corrupted word can never fire a command.

The input has a valid flag but no ready signal. The block accepts every valid word in the cycle it is presented and never applies back-pressure, because fast commands are tied to the word on which they arrive. Every result appears registered in the following cycle.

Top module: `fcmd_decode`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, all outputs are low.
- R2: A valid, correctable symbol with code 0x1 (trigger), 0x2 (register reset), 0x3 (calibration start), 0x4 (resync), 0x5 (event counter reset), 0x6 (bunch counter reset) or 0x7 (run-mode toggle) raises the matching output for exactly the next clock cycle. No other output rises in that cycle.
- R3: Repeated valid symbols with the same command code raise that output in every following cycle, one pulse per symbol. Alternating codes move the pulse between outputs cycle by cycle.
- R4: A valid, correctable symbol with code 0x8 or 0x9 raises sc_stb in the next cycle. sc_bit is 0 for code 0x8 and 1 for code 0x9, and no command output or error rises.
- R5: A valid, correctable symbol with code 0x0 or any code from 0xA to 0xF raises err in the next cycle only. No command pulse and no strobe appear.
- R6: A valid symbol with sym_bad high raises err in the next cycle and nothing else, whatever its code.
- R7: When sym_valid is low, every output is low in the next cycle, whatever sym_code and sym_bad hold.
- R8: At most one of the nine pulse outputs (seven commands, sc_stb, err) is high in any cycle.
- R9: sc_bit is low in every cycle in which sc_stb is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_code | input | 4 | Decoded 4-bit command value |
| sym_bad | input | 1 | Symbol was flagged uncorrectable by the decoder |
| trig | output | 1 | Trigger pulse (code 0x1) |
| reg_rst | output | 1 | Register reset pulse (code 0x2) |
| cal_start | output | 1 | Calibration pulse start (code 0x3) |
| resync | output | 1 | Resync pulse (code 0x4) |
| evt_cnt_rst | output | 1 | Event counter reset pulse (code 0x5) |
| bx_cnt_rst | output | 1 | Bunch counter reset pulse (code 0x6) |
| run_toggle | output | 1 | Run-mode toggle pulse (code 0x7) |
| sc_stb | output | 1 | Slow-control bit strobe (code 0x8 or 0x9) |
| sc_bit | output | 1 | Slow-control bit value, valid with sc_stb |
| err | output | 1 | Unassigned or uncorrectable symbol |

## Verification
Every output of this block is due exactly one word clock after the symbol that causes it: one register lies between the input pins and all ten outputs. The bench drives each symbol on a falling edge. It lets one rising edge pass, then compares the whole output vector at the next falling edge, before it drives the following symbol. In this way a back-to-back stream is checked cycle by cycle, and a stale or late pulse appears as a mismatch on the word where it does not belong. The expected vector comes from a code table in the bench that is written from the requirements alone.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned NUM_CMD = 7;

  // Output vector layout: commands in the low bits, then strobe, bit, error
  localparam int unsigned IDX_STB = NUM_CMD;
  localparam int unsigned IDX_BIT = NUM_CMD + 1;
  localparam int unsigned IDX_ERR = NUM_CMD + 2;
  localparam int unsigned OUT_W   = NUM_CMD + 3;

  typedef enum logic [CODE_W-1:0] {
    C_TRIG    = 4'h1,
    C_REGRST  = 4'h2,
    C_CAL     = 4'h3,
    C_RESYNC  = 4'h4,
    C_EVRST   = 4'h5,
    C_BXRST   = 4'h6,
    C_RUNTOG  = 4'h7,
    C_SC_ZERO = 4'h8,
    C_SC_ONE  = 4'h9
  } fcmd_code_e;

  // Command i (0..NUM_CMD-1) is carried by this code value
  function automatic logic [CODE_W-1:0] cmd_code(input int unsigned idx);
    case (idx)
      0:       return C_TRIG;
      1:       return C_REGRST;
      2:       return C_CAL;
      3:       return C_RESYNC;
      4:       return C_EVRST;
      5:       return C_BXRST;
      default: return C_RUNTOG;
    endcase
  endfunction

endpackage

// File: rtl/fcmd_classify.sv
module fcmd_classify
  import fcmd_pkg::*;
#(
  parameter int unsigned N_CMD = NUM_CMD
) (
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_bad,
  output logic [N_CMD-1:0]  cmd_hit,
  output logic              sc_hit,
  output logic              sc_val,
  output logic              err_hit
);

  logic accept;
  logic any_cmd;

  assign accept = in_valid && !in_bad;

  // One comparator per command code
  for (genvar gi = 0; gi < N_CMD; gi++) begin : g_cmd
    assign cmd_hit[gi] = accept && (in_code == cmd_code(gi));
  end

  assign any_cmd = |cmd_hit;

  always_comb begin
    sc_hit  = 1'b0;
    sc_val  = 1'b0;
    if (accept) begin
      if (in_code == C_SC_ZERO) begin
        sc_hit = 1'b1;
      end else if (in_code == C_SC_ONE) begin
        sc_hit = 1'b1;
        sc_val = 1'b1;
      end
    end
  end

  // Error: uncorrectable word, or a correctable word that maps to nothing
  assign err_hit = in_valid && (in_bad || (!any_cmd && !sc_hit));

endmodule

// File: rtl/fcmd_pulse_reg.sv
module fcmd_pulse_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Per-bit flops: each output is a fresh one-cycle pulse of its comb input
  for (genvar gb = 0; gb < W; gb++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[gb] <= 1'b0;
      else        q[gb] <= d[gb];
    end
  end

endmodule

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [CODE_W-1:0] sym_code,
  input  logic              sym_bad,
  output logic              trig,
  output logic              reg_rst,
  output logic              cal_start,
  output logic              resync,
  output logic              evt_cnt_rst,
  output logic              bx_cnt_rst,
  output logic              run_toggle,
  output logic              sc_stb,
  output logic              sc_bit,
  output logic              err
);

  logic [NUM_CMD-1:0] cmd_hit;
  logic               sc_hit;
  logic               sc_val;
  logic               err_hit;
  logic [OUT_W-1:0]   nxt_vec;
  logic [OUT_W-1:0]   out_vec;

  fcmd_classify #(.N_CMD(NUM_CMD)) u_classify (
    .in_valid (sym_valid),
    .in_code  (sym_code),
    .in_bad   (sym_bad),
    .cmd_hit  (cmd_hit),
    .sc_hit   (sc_hit),
    .sc_val   (sc_val),
    .err_hit  (err_hit)
  );

  always_comb begin
    nxt_vec                = '0;
    nxt_vec[NUM_CMD-1:0]   = cmd_hit;
    nxt_vec[IDX_STB]       = sc_hit;
    nxt_vec[IDX_BIT]       = sc_val;
    nxt_vec[IDX_ERR]       = err_hit;
  end

  fcmd_pulse_reg #(.W(OUT_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt_vec),
    .q     (out_vec)
  );

  assign trig        = out_vec[0];
  assign reg_rst     = out_vec[1];
  assign cal_start   = out_vec[2];
  assign resync      = out_vec[3];
  assign evt_cnt_rst = out_vec[4];
  assign bx_cnt_rst  = out_vec[5];
  assign run_toggle  = out_vec[6];
  assign sc_stb      = out_vec[IDX_STB];
  assign sc_bit      = out_vec[IDX_BIT];
  assign err         = out_vec[IDX_ERR];

endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid,
  input logic [3:0] sym_code,
  input logic       sym_bad,
  input logic       trig,
  input logic       reg_rst,
  input logic       cal_start,
  input logic       resync,
  input logic       evt_cnt_rst,
  input logic       bx_cnt_rst,
  input logic       run_toggle,
  input logic       sc_stb,
  input logic       sc_bit,
  input logic       err
);

  logic       good_in;
  logic       unassigned;
  logic [8:0] pulses;

  assign good_in    = sym_valid && !sym_bad;
  assign unassigned = (sym_code == 4'h0) || (sym_code > 4'h9);
  assign pulses     = {err, sc_stb, run_toggle, bx_cnt_rst, evt_cnt_rst,
                       resync, cal_start, reg_rst, trig};

  // R1: outputs are quiet while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pulses == '0 && !sc_bit);
    end
  end

  assert_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good_in && sym_code == 4'h1 |=> trig);

  assert_regrst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good_in && sym_code == 4'h2 |=> reg_rst);

  assert_runtog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good_in && sym_code == 4'h7 |=> run_toggle);

  assert_trig_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(good_in) && $past(sym_code) == 4'h1);

  assert_sc_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    good_in && sym_code == 4'h9 |=> sc_stb && sc_bit);

  assert_sc_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    good_in && sym_code == 4'h8 |=> sc_stb && !sc_bit);

  assert_unassigned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    good_in && unassigned |=> err);

  assert_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_bad |=> err);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> pulses == '0 && !sc_bit);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  assert_bit_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_stb |-> !sc_bit);

endmodule

bind fcmd_decode fcmd_checker u_fcmd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_valid   (sym_valid),
  .sym_code    (sym_code),
  .sym_bad     (sym_bad),
  .trig        (trig),
  .reg_rst     (reg_rst),
  .cal_start   (cal_start),
  .resync      (resync),
  .evt_cnt_rst (evt_cnt_rst),
  .bx_cnt_rst  (bx_cnt_rst),
  .run_toggle  (run_toggle),
  .sc_stb      (sc_stb),
  .sc_bit      (sc_bit),
  .err         (err)
);

// File: tb/test_fcmd_decode.sv
`timescale 1ns/1ps
module test_fcmd_decode;

  localparam real T_CLK = 8.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [3:0] sym_code = 4'h0;
  logic       sym_bad = 1'b0;
  logic trig, reg_rst, cal_start, resync, evt_cnt_rst, bx_cnt_rst;
  logic run_toggle, sc_stb, sc_bit, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  fcmd_decode i_fcmd_decode (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
    .sym_bad(sym_bad), .trig(trig), .reg_rst(reg_rst), .cal_start(cal_start),
    .resync(resync), .evt_cnt_rst(evt_cnt_rst), .bx_cnt_rst(bx_cnt_rst),
    .run_toggle(run_toggle), .sc_stb(sc_stb), .sc_bit(sc_bit), .err(err)
  );

  // Observed vector: {err, sc_bit, sc_stb, run, bx, ev, resync, cal, regrst, trig}
  function automatic logic [9:0] observed();
    return {err, sc_bit, sc_stb, run_toggle, bx_cnt_rst, evt_cnt_rst,
            resync, cal_start, reg_rst, trig};
  endfunction

  // Expected vector written from the requirements' code table
  function automatic logic [9:0] expect_of(logic v, logic b, logic [3:0] c);
    logic [9:0] e;
    e = '0;
    if (!v)      return e;        // R7
    if (b) begin e[9] = 1'b1; return e; end   // R6
    case (c)
      4'h1: e[0] = 1'b1;
      4'h2: e[1] = 1'b1;
      4'h3: e[2] = 1'b1;
      4'h4: e[3] = 1'b1;
      4'h5: e[4] = 1'b1;
      4'h6: e[5] = 1'b1;
      4'h7: e[6] = 1'b1;
      4'h8: e[7] = 1'b1;
      4'h9: begin e[7] = 1'b1; e[8] = 1'b1; end
      default: e[9] = 1'b1;       // R5
    endcase
    return e;
  endfunction

  task automatic check_vec(string req, logic [9:0] exp_v);
    n_cmp++;
    if (observed() !== exp_v) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, observed(), exp_v, $time);
    end
  endtask

  // Drive one symbol on a falling edge; results are checked at the next falling edge
  logic [9:0] pend_exp;
  string      pend_req;
  bit         pend = 1'b0;

  task automatic drive(string req, logic v, logic b, logic [3:0] c);
    @(negedge clk);
    if (pend) check_vec(pend_req, pend_exp);
    sym_valid = v; sym_bad = b; sym_code = c;
    pend_exp = expect_of(v, b, c);
    pend_req = req;
    pend = 1'b1;
  endtask

  task automatic flush();
    drive("R7", 1'b0, 1'b0, 4'h0);
    @(negedge clk);
    check_vec(pend_req, pend_exp);
    pend = 1'b0;
  endtask

  task automatic t_reset();
    sym_valid = 1'b1; sym_code = 4'h1; sym_bad = 1'b0;
    repeat (3) @(negedge clk);
    check_vec("R1", 10'b0);
    sym_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1", 10'b0);
  endtask

  task automatic t_commands();
    for (int c = 1; c <= 7; c++) begin
      drive("R2", 1'b1, 1'b0, 4'(c));
      drive("R2", 1'b0, 1'b0, 4'(c));   // pulse ends after one cycle
    end
    flush();
  endtask

  task automatic t_back_to_back();
    repeat (4) drive("R3", 1'b1, 1'b0, 4'h1);
    for (int k = 0; k < 6; k++) drive("R3", 1'b1, 1'b0, (k % 2) ? 4'h5 : 4'h2);
    drive("R3", 1'b1, 1'b0, 4'h6);
    drive("R3", 1'b1, 1'b0, 4'h9);
    drive("R3", 1'b1, 1'b0, 4'h4);
    flush();
  endtask

  task automatic t_slow_control();
    logic [15:0] pattern = 16'hA5C3;
    for (int k = 0; k < 16; k++)
      drive("R4", 1'b1, 1'b0, pattern[k] ? 4'h9 : 4'h8);
    drive("R9", 1'b1, 1'b0, 4'h3);
    drive("R4", 1'b1, 1'b0, 4'h9);
    drive("R9", 1'b0, 1'b0, 4'h9);
    flush();
  endtask

  task automatic t_unassigned();
    drive("R5", 1'b1, 1'b0, 4'h0);
    for (int c = 10; c <= 15; c++) drive("R5", 1'b1, 1'b0, 4'(c));
    flush();
  endtask

  task automatic t_uncorrectable();
    for (int c = 0; c <= 15; c++) drive("R6", 1'b1, 1'b1, 4'(c));
    flush();
  endtask

  task automatic t_idle();
    for (int c = 0; c <= 15; c++) drive("R7", 1'b0, c[0], 4'(c));
    drive("R8", 1'b1, 1'b0, 4'h7);
    drive("R7", 1'b0, 1'b1, 4'h1);
    flush();
  endtask

  initial begin
    t_reset();
    t_commands();
    t_back_to_back();
    t_slow_control();
    t_unassigned();
    t_uncorrectable();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(T_CLK * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule